// File: doc/BRIEF.md
# Read Completion Splitter

This block turns accepted read requests into an ordered stream of completions. Each request brings a tag, a byte length of at most 512 bytes, a flag saying whether the target supports it, and the maximum payload size that applies to it. Supported requests are cut into completions whose payload never exceeds that size. Each completion is a header followed by its payload beats, which are taken one by one from the incoming read data stream.

Requests wait in a small first-in first-out queue and are answered strictly in arrival order. An unsupported request is answered with one completer-abort header that carries no payload. The block consumes no read data for such a request.

Top module: `rd_cpl_splitter`

## Requirements
- R1: `req_ready` is low while the queue holds QDEPTH requests, and no request is taken in that state. After reset it is high.
- R2: A supported request is cut into chunks. Each chunk's `cpl_plen` is the smaller of the payload limit and the bytes still owed. The `cfg_mps` code sets the limit: 0 gives 128 bytes, 1 gives 256, 2 gives 512, and 3 gives 128.
- R3: `cpl_bcount` on each header is the byte count still owed before that chunk. On the first header of a request it equals the request length.
- R4: Every header carries the tag of the request it answers.
- R5: An unsupported request produces exactly one header with `cpl_abort` = 1, `cpl_plen` = 0 and `cpl_bcount` equal to the request length. No read data beat is consumed for it.
- R6: Headers come out in the order the requests were accepted. The chunks of one request are never interleaved with those of another.
- R7: After a supported header is accepted, exactly `cpl_plen`/4 payload beats follow before the next header. Each beat forwards `rd_data` unchanged. `pay_valid` and `cpl_valid` are never high together.
- R8: Out of reset, `cpl_valid` and `pay_valid` are low.
- R9: While `cpl_valid` is high and `cpl_ready` is low, the header fields hold steady and `cpl_valid` stays high.
- R10: The payload limit of a request is the `cfg_mps` value seen when that request is accepted. Later changes to `cfg_mps` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mps | input | 2 | Payload limit code, sampled with each request |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room |
| req_tag | input | TAG_W | Request tag |
| req_len | input | LEN_W | Request length in bytes (multiple of 4, 4 to 512) |
| req_ok | input | 1 | Request is supported |
| rd_valid | input | 1 | Read data beat offered |
| rd_ready | output | 1 | Read data beat taken |
| rd_data | input | DATA_W | Read data beat |
| cpl_valid | output | 1 | Completion header valid |
| cpl_ready | input | 1 | Completion header taken |
| cpl_tag | output | TAG_W | Tag of the answered request |
| cpl_bcount | output | LEN_W | Bytes still owed before this chunk |
| cpl_plen | output | LEN_W | Payload bytes in this completion |
| cpl_abort | output | 1 | Completer-abort status |
| pay_valid | output | 1 | Payload beat valid |
| pay_ready | input | 1 | Payload beat taken |
| pay_data | output | DATA_W | Payload beat |
| pay_last | output | 1 | Final beat of this completion |

## Verification
The bench builds the block with its defaults: a 4-deep queue, 32-bit beats and a 512-byte ceiling. The shallow queue lets the bench fill it by holding `cpl_ready` low, which makes the full condition reachable within a few cycles. The 512-byte ceiling lets every limit code be tried, so one request can produce one, two or four chunks, as well as uneven tails such as 132 or 260 bytes. The limit code changes from request to request, and unsupported requests are mixed in, so the bench also covers per-request sampling of the limit and abort answers between data completions.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_DATA = 2'd2
   } rcs_state_e;

   // payload limit in bytes for a configuration code
   function automatic int unsigned mps_bytes(input logic [1:0] code);
      case (code)
         2'd1:    return 256;
         2'd2:    return 512;
         default: return 128;
      endcase
   endfunction

endpackage

// File: rtl/rcs_req_fifo.sv
module rcs_req_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rcs_req_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push && !full) begin
            mem[wr_ptr] <= din;
            wr_ptr      <= wr_ptr + 1'b1;
         end
         if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
         case ({push && !full, pop && !empty})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> (count == $past(count)) || (count == $past(count) - 1'b1));

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      empty |=> !full);

endmodule

// File: rtl/rcs_chunker.sv
module rcs_chunker
   import rcs_pkg::*;
#(
   parameter int TAG_W  = 8,
   parameter int LEN_W  = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_valid,
   input  logic [TAG_W-1:0]  head_tag,
   input  logic [LEN_W-1:0]  head_len,
   input  logic              head_ok,
   input  logic [1:0]        head_mps,
   output logic              head_pop,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cpl_valid,
   input  logic              cpl_ready,
   output logic [TAG_W-1:0]  cpl_tag,
   output logic [LEN_W-1:0]  cpl_bcount,
   output logic [LEN_W-1:0]  cpl_plen,
   output logic              cpl_abort,
   output logic              pay_valid,
   input  logic              pay_ready,
   output logic [DATA_W-1:0] pay_data,
   output logic              pay_last
);
   localparam int BEAT_B = DATA_W / 8;
   localparam int BSH    = $clog2(BEAT_B);

   rcs_state_e       st;
   logic [LEN_W-1:0] rem, mps_b, beats, chunk;
   logic [TAG_W-1:0] tag_q;
   logic             ok_q;

   always_comb begin
      if (!ok_q)             chunk = '0;
      else if (rem < mps_b)  chunk = rem;
      else                   chunk = mps_b;
   end

   assign cpl_valid  = (st == ST_HDR);
   assign cpl_tag    = tag_q;
   assign cpl_bcount = rem;
   assign cpl_plen   = chunk;
   assign cpl_abort  = !ok_q;

   assign pay_valid = (st == ST_DATA) && rd_valid;
   assign rd_ready  = (st == ST_DATA) && pay_ready;
   assign pay_data  = rd_data;
   assign pay_last  = (beats == LEN_W'(1));

   logic beat_go, last_go;
   assign beat_go = pay_valid && pay_ready;
   assign last_go = beat_go && pay_last;

   always_comb begin
      head_pop = 1'b0;
      if (st == ST_HDR && cpl_ready && !ok_q) head_pop = 1'b1;
      if (last_go && rem == chunk)            head_pop = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         rem   <= '0;
         mps_b <= '0;
         beats <= '0;
         tag_q <= '0;
         ok_q  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (head_valid) begin
               rem   <= head_len;
               tag_q <= head_tag;
               ok_q  <= head_ok;
               mps_b <= LEN_W'(mps_bytes(head_mps));
               st    <= ST_HDR;
            end
            ST_HDR: if (cpl_ready) begin
               if (!ok_q) begin
                  st <= ST_IDLE;
               end else begin
                  beats <= chunk >> BSH;
                  st    <= ST_DATA;
               end
            end
            ST_DATA: if (beat_go) begin
               beats <= beats - 1'b1;
               if (pay_last) begin
                  rem <= rem - chunk;
                  st  <= (rem == chunk) ? ST_IDLE : ST_HDR;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_hdr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_tag) && $stable(cpl_bcount)
                                  && $stable(cpl_plen) && $stable(cpl_abort));

   assert_chunk_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && !cpl_abort |-> cpl_plen != '0 && cpl_plen <= cpl_bcount);

   assert_abort_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && cpl_abort && cpl_ready |=> !pay_valid && !rd_ready);

   assert_beat_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(pay_valid && cpl_valid));

   assert_reset_idle_R8: assert property (@(posedge clk)
      !rst_n |=> !cpl_valid && !pay_valid);

endmodule

// File: rtl/rd_cpl_splitter.sv
module rd_cpl_splitter #(
   parameter int TAG_W   = 8,
   parameter int MAX_LEN = 512,
   parameter int DATA_W  = 32,
   parameter int QDEPTH  = 4,
   localparam int LEN_W  = $clog2(MAX_LEN) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mps,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_ok,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cpl_valid,
   input  logic              cpl_ready,
   output logic [TAG_W-1:0]  cpl_tag,
   output logic [LEN_W-1:0]  cpl_bcount,
   output logic [LEN_W-1:0]  cpl_plen,
   output logic              cpl_abort,
   output logic              pay_valid,
   input  logic              pay_ready,
   output logic [DATA_W-1:0] pay_data,
   output logic              pay_last
);
   localparam int ENT_W = TAG_W + LEN_W + 3;

   if (MAX_LEN < 512) begin : g_bad_len
      $error("rd_cpl_splitter: MAX_LEN must cover the largest payload limit");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("rd_cpl_splitter: DATA_W must be a power of two bytes");
   end

   logic             q_full, q_empty, q_pop;
   logic [ENT_W-1:0] q_din, q_dout;

   assign req_ready = !q_full;
   assign q_din     = {cfg_mps, req_ok, req_len, req_tag};

   rcs_req_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (req_valid),
      .din   (q_din),
      .full  (q_full),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty)
   );

   rcs_chunker #(.TAG_W(TAG_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_chunk (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (!q_empty),
      .head_tag   (q_dout[TAG_W-1:0]),
      .head_len   (q_dout[TAG_W +: LEN_W]),
      .head_ok    (q_dout[TAG_W+LEN_W]),
      .head_mps   (q_dout[ENT_W-1 -: 2]),
      .head_pop   (q_pop),
      .rd_valid   (rd_valid),
      .rd_ready   (rd_ready),
      .rd_data    (rd_data),
      .cpl_valid  (cpl_valid),
      .cpl_ready  (cpl_ready),
      .cpl_tag    (cpl_tag),
      .cpl_bcount (cpl_bcount),
      .cpl_plen   (cpl_plen),
      .cpl_abort  (cpl_abort),
      .pay_valid  (pay_valid),
      .pay_ready  (pay_ready),
      .pay_data   (pay_data),
      .pay_last   (pay_last)
   );

   assert_full_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready && !cpl_valid && !pay_valid |=> !req_ready);

endmodule

// File: tb/rd_cpl_splitter_tb.sv
module rd_cpl_splitter_tb;
   localparam int TAG_W = 8, DATA_W = 32, QDEPTH = 4, LEN_W = 10;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic [1:0] cfg_mps = '0;
   logic req_valid = 1'b0, req_ok = 1'b0;
   logic [TAG_W-1:0] req_tag = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic rd_valid = 1'b0, cpl_ready = 1'b0, pay_ready = 1'b0;
   logic [DATA_W-1:0] rd_data = '0;
   logic req_ready, rd_ready, cpl_valid, cpl_abort, pay_valid, pay_last;
   logic [TAG_W-1:0] cpl_tag;
   logic [LEN_W-1:0] cpl_bcount, cpl_plen;
   logic [DATA_W-1:0] pay_data;

   rd_cpl_splitter u_dut (.*);

   typedef struct { int tag; int len; bit ok; int mps; } req_t;
   typedef struct { int tag; int bc; int pl; bit ab; } hdr_t;

   req_t pend[$];
   hdr_t expq[$];
   int checks = 0, errors = 0, cyc = 0, accepted = 0;
   int beats_left = 0, dcount = 0, exp_data = 0;
   bit hold_hdr = 0, prev_hold = 0;
   hdr_t prev_h;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
      end
   endtask

   function automatic int lim(input int code);
      return (code == 1) ? 256 : (code == 2) ? 512 : 128;
   endfunction

   function automatic void model_accept(input req_t r);
      int rem = r.len;
      int m = lim(r.mps);
      if (!r.ok) expq.push_back('{r.tag, r.len, 0, 1'b1});
      else while (rem > 0) begin
         int c = (rem < m) ? rem : m;
         expq.push_back('{r.tag, rem, c, 1'b0});
         rem -= c;
      end
   endfunction

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
         chk(1'b0, "watchdog", cyc, 0);
         finish_run();
      end
      cpl_ready = hold_hdr ? 1'b0 : ($urandom % 4 != 0);
      pay_ready = ($urandom % 4 != 0);
      rd_valid  = ($urandom % 3 != 0);
      rd_data   = dcount;
      if (pend.size() > 0) begin
         req_valid = 1'b1;
         req_tag   = pend[0].tag[TAG_W-1:0];
         req_len   = pend[0].len[LEN_W-1:0];
         req_ok    = pend[0].ok;
         cfg_mps   = pend[0].mps[1:0];
      end else begin
         req_valid = 1'b0;
         cfg_mps   = 2'($urandom % 4);   // changes while idle must not matter (R10)
      end
      #1;
      if (req_valid && req_ready) begin
         model_accept(pend.pop_front());
         accepted++;
      end
      if (cpl_valid) begin
         chk(!pay_valid, "R7 header/beat overlap", pay_valid, 0);
         if (prev_hold)
            chk(cpl_tag == prev_h.tag && cpl_bcount == prev_h.bc && cpl_plen == prev_h.pl
                && cpl_abort == prev_h.ab, "R9 held header changed", cpl_bcount, prev_h.bc);
         if (cpl_ready) begin
            if (expq.size() == 0) chk(1'b0, "R6 unexpected header", cpl_tag, -1);
            else begin
               hdr_t e = expq.pop_front();
               chk(cpl_tag == e.tag, "R4 R6 tag", cpl_tag, e.tag);
               chk(cpl_bcount == e.bc, "R3 byte count", cpl_bcount, e.bc);
               chk(cpl_plen == e.pl, "R2 R10 payload length", cpl_plen, e.pl);
               chk(cpl_abort == e.ab, "R5 abort status", cpl_abort, e.ab);
            end
            chk(beats_left == 0, "R7 beats before header", beats_left, 0);
            if (cpl_abort) chk(!rd_ready, "R5 data taken on abort", rd_ready, 0);
            beats_left = cpl_plen / 4;
         end
      end else if (prev_hold) chk(1'b0, "R9 header dropped", 0, 1);
      prev_hold = cpl_valid && !cpl_ready;
      prev_h = '{cpl_tag, cpl_bcount, cpl_plen, cpl_abort};
      if (pay_valid && pay_ready) begin
         chk(beats_left > 0, "R7 extra beat", beats_left, 1);
         chk(pay_data == exp_data, "R7 beat data", pay_data, exp_data);
         chk(pay_last == (beats_left == 1), "R7 last flag", pay_last, beats_left == 1);
         exp_data++;
         beats_left--;
      end
      if (rd_valid && rd_ready) dcount++;
   endtask

   task automatic add(input int tag, input int len, input bit ok, input int mps);
      pend.push_back('{tag, len, ok, mps});
   endtask

   task automatic drain();
      int guard = 0;
      while ((pend.size() > 0 || expq.size() > 0 || beats_left > 0) && guard < 20000) begin
         step();
         guard++;
      end
      for (int i = 0; i < 4; i++) step();
      chk(expq.size() == 0 && beats_left == 0, "R6 completions missing", expq.size(), 0);
   endtask

   initial begin
      for (int i = 0; i < 3; i++) @(negedge clk);
      #1;
      chk(!cpl_valid && !pay_valid, "R8 reset outputs", {cpl_valid, pay_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      chk(!cpl_valid && !pay_valid, "R8 idle after reset", {cpl_valid, pay_valid}, 0);

      // 512 bytes at a 128-byte limit gives four chunks (R2)
      add(8'h11, 512, 1, 0);
      drain();
      // one chunk at 512, two at 256, uneven tails
      add(8'h21, 512, 1, 2);
      add(8'h22, 512, 1, 1);
      add(8'h23, 132, 1, 0);
      add(8'h24, 260, 1, 1);
      add(8'h25, 4, 1, 3);
      drain();
      // aborts between data completions, limit code changes per request (R5 R10)
      add(8'h31, 256, 0, 0);
      add(8'h32, 384, 1, 2);
      add(8'h33, 512, 0, 1);
      add(8'h34, 300, 1, 1);
      add(8'h35, 8, 0, 3);
      drain();

      // queue full (R1): hold headers back and offer more than the queue holds
      hold_hdr = 1;
      accepted = 0;
      for (int i = 0; i < QDEPTH + 2; i++) add(8'h40 + i, 64, 1, 0);
      for (int i = 0; i < QDEPTH + 6; i++) step();
      chk(accepted == QDEPTH, "R1 accepted while full", accepted, QDEPTH);
      chk(!req_ready, "R1 ready while full", req_ready, 0);
      hold_hdr = 0;
      drain();

      // mixed random traffic
      for (int i = 0; i < 40; i++)
         add(i, 4 * (1 + $urandom % 128), ($urandom % 5 != 0), $urandom % 4);
      drain();
      finish_run();
   end
endmodule